// File: doc/BRIEF.md
# Fixed-Format Instruction Word Atom Dispatcher

The dispatcher sits between an instruction fetch stage and the execution units of a wide-issue core. Each cycle it can take one long instruction word, a molecule, over a valid/ready handshake. A narrow molecule is 64 bits and carries two 32-bit atoms. A wide molecule is 128 bits and carries four. Each atom carries a unit-class code, and that code alone picks the execution unit. The dispatcher needs no dependency tracking and no reordering. All atoms of an accepted molecule appear on their unit ports together, one cycle after the handshake.

There are five target units: two integer ALUs, a floating-point unit, a memory unit and a branch unit. Software fills slots that have no useful work with no-op atoms, which are dropped. A molecule that names the same unit twice is consumed without issuing anything, and an error pulse marks it. For every issued atom the dispatcher also brings out its three register-operand indices, each selecting one of 64 integer registers.

Top module: `atom_dispatch`

## Requirements
- R1: While `rst_n` is low, `mol_ready`, every `unit_valid` bit and `mol_error` are low. A molecule presented in the first cycle with `rst_n` high is accepted at that cycle's clock edge.
- R2: An atom is 32 bits with this layout: bits [31:29] unit class, [28:23] operand index A, [22:17] operand index B, [16:11] operand index C, [10:0] immediate/opcode. Slot k occupies `mol_data[32k+31:32k]`.
- R3: When `mol_wide` is 0, only slots 0 and 1 are decoded. Bits [127:64] have no effect on any output.
- R4: When `mol_wide` is 1, slots 0 through 3 are all decoded.
- R5: A class code from 0 to 4 routes the atom to the unit with that index: 0 ALU0, 1 ALU1, 2 FPU, 3 MEM, 4 BRANCH. The atom appears unmodified on `unit_atom[32u+31:32u]`, with `unit_valid[u]` high, for exactly the one cycle after acceptance.
- R6: Class codes 5, 6 and 7 are no-ops. They are not routed, and they need no unit to be ready.
- R7: All routed atoms of one molecule have their `unit_valid` bits raised in the same cycle.
- R8: If two decoded atoms share a class code from 0 to 4, the molecule is accepted regardless of `unit_ready`. `mol_error` is then high for one cycle and no `unit_valid` bit rises.
- R9: A conflict-free molecule is accepted only when `unit_ready` is high for every unit it addresses. Until then `mol_ready` is low and nothing issues.
- R10: The `unit_ra`, `unit_rb` and `unit_rc` slices for unit u equal operand fields A, B and C of the atom on `unit_atom` for that unit.
- R11: In a cycle that follows no handshake, every `unit_valid` bit and `mol_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mol_valid | input | 1 | Molecule present |
| mol_ready | output | 1 | Molecule accepted at this edge if valid |
| mol_wide | input | 1 | 1 = 128-bit four-atom molecule, 0 = 64-bit two-atom |
| mol_data | input | 128 | Molecule bits, slot 0 in the low word |
| unit_ready | input | 5 | Per-unit readiness to take an atom next cycle |
| unit_valid | output | 5 | Per-unit atom issue strobe |
| unit_atom | output | 160 | Per-unit 32-bit atom payload |
| unit_ra | output | 30 | Per-unit 6-bit operand index A |
| unit_rb | output | 30 | Per-unit 6-bit operand index B |
| unit_rc | output | 30 | Per-unit 6-bit operand index C |
| mol_error | output | 1 | One-cycle pulse for a consumed molecule with a duplicate unit class |

## Verification
The bench first sweeps every combination of the eight class codes across the four slots of a wide molecule. This separates correct routing from swapped unit indices, missed slots, undetected duplicates and no-ops that are wrongly routed. It then sweeps every class pair of a narrow molecule whose upper half holds live, conflicting atoms. Any leak of bits [127:64] shows up as a wrong route or a false error. The narrow sweep is repeated with no unit ready, which shows that only routed classes wait on readiness. Finally, a fixed four-unit molecule meets all 32 readiness masks. This tells apart a stall on any addressed unit from one on an unaddressed unit. Reset, release timing and idle cycles are checked separately.

// File: rtl/atom_dispatch_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the atom record for the dispatcher.
// Assumes a fixed 32-bit atom whose field order is decoded downstream.
package atom_dispatch_pkg;
    localparam int CLS_W       = 3;
    localparam int REG_W       = 6;
    localparam int IMM_W       = 11;
    localparam int ATOM_W      = CLS_W + 3 * REG_W + IMM_W;
    localparam int N_UNITS     = 5;
    localparam int WIDE_SLOTS  = 4;
    localparam int NARROW_SLOTS = 2;
    localparam int MOL_W       = WIDE_SLOTS * ATOM_W;

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rc;
        logic [IMM_W-1:0] imm;
    } atom_t;
endpackage

// File: rtl/atom_slot_decode.sv
`timescale 1ns/1ps
// Module: atom_slot_decode
// Turns one slot's atom into a one-hot claim on the unit it names.
// Assumes: slots at or above NARROW_SLOTS are live only for wide molecules;
// class codes at or above N_UNITS are no-ops and claim nothing.
module atom_slot_decode
    import atom_dispatch_pkg::*;
#(
    parameter int SLOT_IDX = 0
) (
    input  atom_t              atom,
    input  logic               wide,
    output logic [N_UNITS-1:0] claim
);
    localparam bit ALWAYS_LIVE = (SLOT_IDX < NARROW_SLOTS);

    logic live;

    generate
        if (ALWAYS_LIVE) begin : g_always
            assign live = 1'b1;
        end else begin : g_wide_only
            assign live = wide;
        end
    endgenerate

    // Raise the bit of the addressed unit for a live, non-no-op slot.
    always_comb begin
        claim = '0;
        if (live && (int'(atom.cls) < N_UNITS))
            claim[atom.cls] = 1'b1;
    end
endmodule

// File: rtl/atom_router.sv
`timescale 1ns/1ps
// Module: atom_router
// Gathers slot claims into a per-unit atom selection, the set of needed
// units, and a conflict flag when two slots name one unit.
// Assumes claims are one-hot or zero per slot.
module atom_router
    import atom_dispatch_pkg::*;
(
    input  logic  [WIDE_SLOTS-1:0][N_UNITS-1:0] claim,
    input  atom_t [WIDE_SLOTS-1:0]              atoms,
    output logic  [N_UNITS-1:0]                 need,
    output logic                                conflict,
    output atom_t [N_UNITS-1:0]                 sel
);
    // Scan slots per unit; a second claim on a unit marks a conflict.
    always_comb begin
        need     = '0;
        conflict = 1'b0;
        sel      = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            for (int s = 0; s < WIDE_SLOTS; s++) begin
                if (claim[s][u]) begin
                    if (need[u])
                        conflict = 1'b1;
                    need[u] = 1'b1;
                    sel[u]  = atoms[s];
                end
            end
        end
    end
endmodule

// File: rtl/atom_issue_reg.sv
`timescale 1ns/1ps
// Module: atom_issue_reg
// Output stage: holds the per-unit strobes and payloads for one cycle
// after a handshake, or the error pulse for a conflicting molecule.
// Assumes fire is the accepted handshake; synchronous active-low reset.
module atom_issue_reg
    import atom_dispatch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic                conflict,
    input  logic [N_UNITS-1:0]  need,
    input  atom_t [N_UNITS-1:0] sel,
    output logic [N_UNITS-1:0]  issue,
    output atom_t [N_UNITS-1:0] payload,
    output logic                err
);
    // Strobes and error pulse: set only by an accepted molecule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue <= '0;
            err   <= 1'b0;
        end else begin
            issue <= (fire && !conflict) ? need : '0;
            err   <= fire && conflict;
        end
    end

    // Payload capture: load on a clean accept, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            payload <= '0;
        else if (fire && !conflict)
            payload <= sel;
    end

    // R8: an error cycle never issues an atom.
    a_r8_error_excludes_issue: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (issue == '0));

    // R11: with no handshake, nothing is driven the next cycle.
    a_r11_idle_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (issue == '0) && !err);
endmodule

// File: rtl/atom_dispatch.sv
`timescale 1ns/1ps
// Module: atom_dispatch (top)
// Splits a 64- or 128-bit molecule into atoms and issues each to the
// execution unit named by its class code, all in the same cycle.
// Assumes upstream holds a stalled molecule unchanged; synchronous
// active-low reset; acceptance begins the first cycle reset is high.
module atom_dispatch
    import atom_dispatch_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mol_valid,
    output logic                         mol_ready,
    input  logic                         mol_wide,
    input  logic [MOL_W-1:0]             mol_data,
    input  logic [N_UNITS-1:0]           unit_ready,
    output logic [N_UNITS-1:0]           unit_valid,
    output logic [N_UNITS*ATOM_W-1:0]    unit_atom,
    output logic [N_UNITS*REG_W-1:0]     unit_ra,
    output logic [N_UNITS*REG_W-1:0]     unit_rb,
    output logic [N_UNITS*REG_W-1:0]     unit_rc,
    output logic                         mol_error
);
    logic  [WIDE_SLOTS-1:0][N_UNITS-1:0] claim;
    atom_t [WIDE_SLOTS-1:0]              atoms;
    logic  [N_UNITS-1:0]                 need;
    logic                                conflict;
    atom_t [N_UNITS-1:0]                 sel;
    atom_t [N_UNITS-1:0]                 payload;
    logic                                fire;

    genvar s, u;
    generate
        for (s = 0; s < WIDE_SLOTS; s++) begin : g_slot
            assign atoms[s] = atom_t'(mol_data[s*ATOM_W +: ATOM_W]);
            atom_slot_decode #(.SLOT_IDX(s)) u_dec (
                .atom  (atoms[s]),
                .wide  (mol_wide),
                .claim (claim[s])
            );
        end
    endgenerate

    atom_router u_route (
        .claim    (claim),
        .atoms    (atoms),
        .need     (need),
        .conflict (conflict),
        .sel      (sel)
    );

    // Accept when out of reset and either rejecting or all targets ready.
    always_comb begin
        mol_ready = rst_n && (conflict || ((need & ~unit_ready) == '0));
    end

    assign fire = mol_valid && mol_ready;

    atom_issue_reg u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .conflict (conflict),
        .need     (need),
        .sel      (sel),
        .issue    (unit_valid),
        .payload  (payload),
        .err      (mol_error)
    );

    generate
        for (u = 0; u < N_UNITS; u++) begin : g_unit
            assign unit_atom[u*ATOM_W +: ATOM_W] = payload[u];
            assign unit_ra[u*REG_W +: REG_W]     = payload[u].ra;
            assign unit_rb[u*REG_W +: REG_W]     = payload[u].rb;
            assign unit_rc[u*REG_W +: REG_W]     = payload[u].rc;

            // R5: an issued atom carries the class code of its unit.
            a_r5_class_matches_unit: assert property (@(posedge clk) disable iff (!rst_n)
                unit_valid[u] |-> (int'(payload[u].cls) == u));

            // R9: a unit only receives an atom it was ready for.
            a_r9_ready_at_accept: assert property (@(posedge clk) disable iff (!rst_n)
                unit_valid[u] |-> $past(unit_ready[u]));
        end
    endgenerate

    // R7: a clean accept raises every needed unit together, one cycle later.
    a_r7_same_cycle_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !conflict) |=> (unit_valid == $past(need)));

    // R8: the error pulse only follows an accepted molecule.
    a_r8_error_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mol_error |-> $past(mol_valid && mol_ready));
endmodule

// File: tb/atom_dispatch_tb.sv
`timescale 1ns/1ps
module atom_dispatch_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mol_valid = 1'b0;
    logic         mol_ready;
    logic         mol_wide = 1'b0;
    logic [127:0] mol_data = '0;
    logic [4:0]   unit_ready = '0;
    logic [4:0]   unit_valid;
    logic [159:0] unit_atom;
    logic [29:0]  unit_ra, unit_rb, unit_rc;
    logic         mol_error;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    atom_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .mol_valid(mol_valid), .mol_ready(mol_ready),
        .mol_wide(mol_wide), .mol_data(mol_data), .unit_ready(unit_ready),
        .unit_valid(unit_valid), .unit_atom(unit_atom), .unit_ra(unit_ra),
        .unit_rb(unit_rb), .unit_rc(unit_rc), .mol_error(mol_error)
    );

    task automatic chk(input bit ok, input string tag, input logic [159:0] act,
                       input logic [159:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_atom(input int slot, input int cls, input int v);
        logic [5:0]  a = 6'(v + slot);
        logic [5:0]  b = 6'(v * 3 + slot);
        logic [5:0]  c = 6'(v ^ (slot * 17));
        logic [10:0] im = 11'(v * 7 + slot);
        return {3'(cls), a, b, c, im};
    endfunction

    // Check the issued outputs against expected need and payloads.
    task automatic check_issue(input logic [4:0] need, input logic [31:0] exp_atom [5]);
        chk(unit_valid == need, "R5 R7 unit_valid", 160'(unit_valid), 160'(need));
        chk(mol_error == 1'b0, "R8 no error", 160'(mol_error), 160'(0));
        for (int u = 0; u < 5; u++) begin
            if (need[u]) begin
                chk(unit_atom[u*32 +: 32] == exp_atom[u], "R2 R3 R4 R5 payload",
                    160'(unit_atom[u*32 +: 32]), 160'(exp_atom[u]));
                chk({unit_ra[u*6 +: 6], unit_rb[u*6 +: 6], unit_rc[u*6 +: 6]} ==
                    exp_atom[u][28:11], "R10 operand indices",
                    160'({unit_ra[u*6 +: 6], unit_rb[u*6 +: 6], unit_rc[u*6 +: 6]}),
                    160'(exp_atom[u][28:11]));
            end
        end
    endtask

    // Present one molecule starting at a negedge; checks end at a negedge.
    task automatic run_vec(input logic [127:0] d, input logic w, input logic [4:0] rdy);
        logic [4:0]  need = '0;
        bit          conf = 0;
        bit          exp_rdy;
        logic [31:0] exp_atom [5];
        for (int u = 0; u < 5; u++) exp_atom[u] = '0;
        for (int s = 0; s < (w ? 4 : 2); s++) begin
            logic [31:0] a = d[s*32 +: 32];
            int c = int'(a[31:29]);
            if (c < 5) begin
                if (need[c]) conf = 1;
                need[c] = 1'b1;
                exp_atom[c] = a;
            end
        end
        exp_rdy = conf || ((need & ~rdy) == 5'd0);
        mol_valid = 1'b1; mol_data = d; mol_wide = w; unit_ready = rdy;
        #1;
        chk(mol_ready == exp_rdy, "R6 R8 R9 mol_ready", 160'(mol_ready), 160'(exp_rdy));
        @(negedge clk);
        if (!exp_rdy) begin
            chk(unit_valid == 5'd0 && !mol_error, "R9 stalled no issue",
                160'({mol_error, unit_valid}), 160'(0));
            unit_ready = 5'h1f;
            #1;
            chk(mol_ready == 1'b1, "R9 ready once units ready", 160'(mol_ready), 160'(1));
            @(negedge clk);
        end
        mol_valid = 1'b0;
        if (conf) begin
            chk(unit_valid == 5'd0, "R8 conflict no issue", 160'(unit_valid), 160'(0));
            chk(mol_error == 1'b1, "R8 error pulse", 160'(mol_error), 160'(1));
        end else begin
            check_issue(need, exp_atom);
        end
        @(negedge clk);
        chk(unit_valid == 5'd0 && !mol_error, "R11 idle after issue",
            160'({mol_error, unit_valid}), 160'(0));
    endtask

    initial begin
        logic [127:0] d;
        logic [31:0]  e [5];
        // R1: reset holds everything low even with a molecule offered.
        mol_valid = 1'b1; mol_wide = 1'b0; unit_ready = 5'h1f;
        mol_data = {64'd0, mk_atom(1, 7, 5), mk_atom(0, 0, 5)};
        repeat (3) @(negedge clk);
        chk(mol_ready == 1'b0, "R1 ready low in reset", 160'(mol_ready), 160'(0));
        chk(unit_valid == 5'd0 && !mol_error, "R1 outputs low in reset",
            160'({mol_error, unit_valid}), 160'(0));
        rst_n = 1'b1;
        #1;
        chk(mol_ready == 1'b1, "R1 ready after release", 160'(mol_ready), 160'(1));
        @(negedge clk);
        mol_valid = 1'b0;
        for (int u = 0; u < 5; u++) e[u] = '0;
        e[0] = mk_atom(0, 0, 5);
        check_issue(5'b00001, e);
        @(negedge clk);

        // R4 R5 R6 R8: all class combinations over four wide slots.
        for (int i = 0; i < 4096; i++) begin
            for (int s = 0; s < 4; s++) d[s*32 +: 32] = mk_atom(s, (i >> (3*s)) & 7, i);
            run_vec(d, 1'b1, 5'h1f);
        end
        // R3: narrow molecules with live conflicting atoms in the upper half.
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 64; i++) begin
                d[31:0]   = mk_atom(0, i & 7, i + 11);
                d[63:32]  = mk_atom(1, (i >> 3) & 7, i + 11);
                d[95:64]  = mk_atom(2, (i + 1) % 5, i);
                d[127:96] = mk_atom(3, (i + 1) % 5, i);
                run_vec(d, 1'b0, (r == 0) ? 5'h1f : 5'h00);
            end
        end
        // R9: one four-unit molecule against every readiness mask.
        for (int m = 0; m < 32; m++) begin
            d = {mk_atom(3, 4, m), mk_atom(2, 3, m), mk_atom(1, 2, m), mk_atom(0, 0, m)};
            run_vec(d, 1'b1, 5'(m));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule